// File: doc/BRIEF.md
# Link Diagnostic Status Register

This block is a small register set in the management space of a copper Ethernet transceiver. It keeps a record of why a link failed to come up. It latches a sticky flag when the fast-link-pulse negotiation exchange finishes but the link logic later reports that no link formed. Software clears this flag by reading it. The block also holds a control bit that turns automatic pair-polarity correction off. It reports the polarity detected on each of the four wire pairs while a gigabit link is active.

The negotiation engine marks the end of an exchange with one strobe. The link logic marks a bring-up timeout with a second strobe and keeps a level for the current link state. The management interface presents a read address with a read strobe and a write address with a write enable. Read data is combinational from the read address. A read strobe takes effect at the clock edge that ends the read cycle.

Top module: `ldiag_regs`

## Requirements
- R1: After reset the sticky flag is 0, the correction-disable bit is 0 and `corr_en_o` is 1.
- R2: Address map. Offset 0 holds the read/write correction-disable bit at bit 0. Offset 1 holds the sticky flag at bit 0. Offset 2 holds the pair polarity at bits 3:0, with bit i for pair i and 1 meaning inverted. All other bits and offsets read 0.
- R3: A write to offset 0 loads bit 0 of the write data into the disable bit at the next edge, and `corr_en_o` is its inverse. A write to any other offset changes nothing.
- R4: The flag is set at the edge where a timeout strobe arrives with link-up low after an exchange-complete strobe (the same cycle or earlier). One exchange completion arms at most one setting: a later timeout without a new completion does not set the flag.
- R5: A timeout strobe with no exchange completion since the last timeout or link-up leaves the flag clear.
- R6: The flag is not set if link-up goes high after the exchange completes, or if link-up is high when the timeout strobe arrives.
- R7: A read strobe at offset 1 returns the current flag and clears it at that edge. Reads of other offsets and writes to offset 1 leave it unchanged.
- R8: If a set event and a clearing read fall in the same cycle, the read returns the old value and the flag is 1 afterwards.
- R9: With a gigabit link up and correction enabled, offset 2 shows the per-pair polarity inputs. With no gigabit link it reads 0.
- R10: While correction is disabled, offset 2 reads 0, because polarity is forced to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_done_i | input | 1 | Strobe: negotiation pulse exchange completed |
| link_fail_i | input | 1 | Strobe: link bring-up timed out |
| link_up_i | input | 1 | Level: link currently up |
| link_gig_i | input | 1 | Level: 1000BASE-T link up |
| pair_pol_i | input | NPAIR | Detected polarity per pair, 1 = inverted |
| rd_stb_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read offset |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `rd_addr_i` |
| corr_en_o | output | 1 | Polarity correction enabled |

## Verification
The assertions check every cycle that a set event leaves the flag at 1. They check that a clearing read with no competing set leaves it at 0, and that the flag only rises after a timeout with the link down. They also check that the polarity view is zero when the link is not gigabit or correction is off, and that the control bit follows writes and otherwise holds. Only the bench scenarios can show the arming history. This covers an exchange that is consumed by a timeout or cancelled by link-up, a read that returns the old value in a collision cycle, and writes or reads at other offsets that leave state untouched.

// File: rtl/ldiag_pkg.sv
package ldiag_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_DIAG = 1;
  localparam int OFS_POL  = 2;

  // Next value of a set-dominant, read-cleared flag.
  function automatic logic sticky_next(input logic cur, input logic set_evt,
                                       input logic clr);
    return set_evt | (cur & ~clr);
  endfunction

  // Arming state for the "exchange done, waiting for link" window.
  function automatic logic arm_next(input logic cur, input logic done,
                                    input logic fail, input logic up);
    if (up || fail) return 1'b0;
    return cur | done;
  endfunction
endpackage

// File: rtl/ldiag_sticky.sv
module ldiag_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic exch_done,
  input  logic fail_stb,
  input  logic link_up,
  input  logic clr_rd,
  output logic flag
);
  import ldiag_pkg::*;

  logic armed;
  logic set_evt;

  assign set_evt = fail_stb & (armed | exch_done) & ~link_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      flag  <= 1'b0;
    end else begin
      armed <= arm_next(armed, exch_done, fail_stb, link_up);
      flag  <= sticky_next(flag, set_evt, clr_rd);
    end
  end

  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set_evt) |=> !flag);
  a_r8_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_rd) |=> flag);
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(fail_stb) && !$past(link_up)));
endmodule

// File: rtl/ldiag_polarity.sv
module ldiag_polarity #(
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gig_up,
  input  logic             corr_en,
  input  logic [NPAIR-1:0] raw_pol,
  output logic [NPAIR-1:0] pol_view
);
  always_comb begin
    pol_view = '0;
    for (int i = 0; i < NPAIR; i++)
      pol_view[i] = raw_pol[i] & gig_up & corr_en;
  end

  a_r9_no_gig_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !gig_up |-> (pol_view == '0));
  a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (gig_up && corr_en) |-> (pol_view == raw_pol));
  a_r10_forced_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |-> (pol_view == '0));
endmodule

// File: rtl/ldiag_ctrl.sv
module ldiag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic dis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dis <= 1'b0;
    else if (wr_hit) dis <= wr_bit;
  end

  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (dis == $past(wr_bit)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(dis));
endmodule

// File: rtl/ldiag_regs.sv
module ldiag_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int NPAIR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_done_i,
  input  logic              link_fail_i,
  input  logic              link_up_i,
  input  logic              link_gig_i,
  input  logic [NPAIR-1:0]  pair_pol_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              corr_en_o
);
  import ldiag_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIAG = ADDR_W'(OFS_DIAG);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);

  logic             ctrl_wr_hit;
  logic             diag_rd_clr;
  logic             dis_bit;
  logic             sticky_flag;
  logic [NPAIR-1:0] pol_view;
  logic             unused_wr_hi;

  assign ctrl_wr_hit  = wr_en_i && (wr_addr_i == A_CTRL);
  assign diag_rd_clr  = rd_stb_i && (rd_addr_i == A_DIAG);
  assign corr_en_o    = ~dis_bit;
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:1];

  ldiag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_wr_hit),
    .wr_bit(wr_data_i[0]), .dis(dis_bit)
  );

  ldiag_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .exch_done(an_done_i), .fail_stb(link_fail_i),
    .link_up(link_up_i), .clr_rd(diag_rd_clr), .flag(sticky_flag)
  );

  ldiag_polarity #(.NPAIR(NPAIR)) u_pol (
    .clk(clk), .rst_n(rst_n), .gig_up(link_gig_i), .corr_en(corr_en_o),
    .raw_pol(pair_pol_i), .pol_view(pol_view)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o[0] = dis_bit;
      A_DIAG:  rd_data_o[0] = sticky_flag;
      A_POL:   rd_data_o[NPAIR-1:0] = pol_view;
      default: rd_data_o = '0;
    endcase
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!sticky_flag && corr_en_o));
endmodule

// File: tb/tb_ldiag_regs.sv
`timescale 1ns/1ps
module tb_ldiag_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic an_done_i = 0, link_fail_i = 0, link_up_i = 0, link_gig_i = 0;
  logic [3:0]  pair_pol_i = 0;
  logic        rd_stb_i = 0, wr_en_i = 0;
  logic [4:0]  rd_addr_i = 0, wr_addr_i = 0;
  logic [15:0] wr_data_i = 0;
  logic [15:0] rd_data_o;
  logic        corr_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldiag_regs dut (
    .clk(clk), .rst_n(rst_n), .an_done_i(an_done_i), .link_fail_i(link_fail_i),
    .link_up_i(link_up_i), .link_gig_i(link_gig_i), .pair_pol_i(pair_pol_i),
    .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .corr_en_o(corr_en_o)
  );

  // {gig, disable, raw[3:0], expected[3:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 1'b0, 4'b1010, 4'b1010},
    {1'b1, 1'b0, 4'b0101, 4'b0101},
    {1'b1, 1'b0, 4'b1111, 4'b1111},
    {1'b0, 1'b0, 4'b1111, 4'b0000},
    {1'b0, 1'b0, 4'b0110, 4'b0000},
    {1'b1, 1'b1, 4'b1111, 4'b0000},
    {1'b1, 1'b1, 4'b1001, 4'b0000},
    {1'b1, 1'b0, 4'b0001, 4'b0001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic clr_read();
    rd_addr_i = 5'd1; rd_stb_i = 1; step(); rd_stb_i = 0;
  endtask

  task automatic exch();
    an_done_i = 1; step(); an_done_i = 0;
  endtask

  task automatic fail();
    link_fail_i = 1; step(); link_fail_i = 0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) step();
    rst_n = 1; step();

    peek(5'd0, d); check("R1 ctrl", d, 16'h0);
    peek(5'd1, d); check("R1 diag", d, 16'h0);
    check("R1 corr_en", {15'b0, corr_en_o}, 16'h1);

    for (int i = 0; i < 8; i++) begin
      wr(5'd0, {15'b0, VEC[i][8]});
      link_gig_i = VEC[i][9]; pair_pol_i = VEC[i][7:4];
      peek(5'd2, d);
      check(VEC[i][8] ? "R10 forced" : "R9 view", d, {12'b0, VEC[i][3:0]});
    end
    link_gig_i = 0;

    wr(5'd0, 16'hFFFF);
    check("R3 corr_en off", {15'b0, corr_en_o}, 16'h0);
    peek(5'd0, d); check("R2 ctrl bits", d, 16'h1);
    wr(5'd0, 16'h0);
    check("R3 corr_en on", {15'b0, corr_en_o}, 16'h1);
    wr(5'd3, 16'h1);
    check("R3 other offset", {15'b0, corr_en_o}, 16'h1);
    peek(5'd7, d); check("R2 unmapped", d, 16'h0);

    exch(); fail();
    peek(5'd1, d); check("R4 set", d, 16'h1);
    rd_addr_i = 5'd1; rd_stb_i = 1; #1;
    check("R7 read returns flag", rd_data_o, 16'h1);
    step(); rd_stb_i = 0;
    peek(5'd1, d); check("R7 cleared", d, 16'h0);
    fail();
    peek(5'd1, d); check("R4 no re-arm", d, 16'h0);

    fail();
    peek(5'd1, d); check("R5 no exchange", d, 16'h0);

    exch(); link_up_i = 1; step(); link_up_i = 0; fail();
    peek(5'd1, d); check("R6 link came up", d, 16'h0);
    exch(); link_up_i = 1; fail(); link_up_i = 0;
    peek(5'd1, d); check("R6 link up at strobe", d, 16'h0);

    an_done_i = 1; link_fail_i = 1; step(); an_done_i = 0; link_fail_i = 0;
    peek(5'd1, d); check("R4 same cycle", d, 16'h1);
    rd_addr_i = 5'd0; rd_stb_i = 1; step(); rd_stb_i = 0;
    peek(5'd1, d); check("R7 other read", d, 16'h1);
    wr(5'd1, 16'h0);
    peek(5'd1, d); check("R7 write ignored", d, 16'h1);

    exch();
    link_fail_i = 1; rd_addr_i = 5'd1; rd_stb_i = 1; #1;
    check("R8 old value", rd_data_o, 16'h1);
    step(); link_fail_i = 0; rd_stb_i = 0;
    peek(5'd1, d); check("R8 kept", d, 16'h1);
    clr_read();
    exch();
    link_fail_i = 1; rd_addr_i = 5'd1; rd_stb_i = 1; #1;
    check("R8 old zero", rd_data_o, 16'h0);
    step(); link_fail_i = 0; rd_stb_i = 0;
    peek(5'd1, d); check("R8 set wins", d, 16'h1);

    rst_n = 0; step(); rst_n = 1; step();
    peek(5'd1, d); check("R1 reset clears", d, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule